// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block generates the SCL clock of an I2C master from a reference clock. A 3-bit prescaler select divides the reference clock by a power of two. The result is a prescaled tick. Two 5-bit counts set how many ticks SCL spends low and how many it spends high. Each phase also carries a fixed overhead. That overhead stands for the SCL synchroniser and the noise filter: four ticks when the prescaler is bypassed (select 0) and three ticks otherwise. The byte engine next to the block uses two strobes. One marks the end of the low phase, where SDA may change. The other marks the middle of the high phase, where SDA is sampled.

Software writes the configuration through three write strobes that share one 8-bit data bus. The prescaler sits in bits 6:4 of the mode write. It is only accepted when bit 3 of the same write is set, which acts as a write-protect key. Both counts read back with their three upper bits forced to 1. A count of zero is stored as 1. Every configuration value is copied into the running phase only at a phase boundary. A change therefore never stretches or cuts short the phase that is already running.

The phase controller has three states. IDLE drives SCL high and moves to LOW on the cycle after enable is seen. LOW moves to HIGH on the last tick of the low phase (transition "low-end"). HIGH moves to LOW on the last tick of the high phase (transition "high-end"). From any state, dropping enable returns to IDLE (transition "abort").

Top module: `scl_rate_gen`

## Requirements
- R1: While running, `tick` pulses once every 2^S reference cycles, where S is the active prescaler select. With S = 0 it pulses on every cycle.
- R2: With S = 0, the low phase lasts (low count + 4) ticks and the high phase lasts (high count + 4) ticks.
- R3: With S between 1 and 7, each phase lasts its count + 3 ticks, which is (count + 3)·2^S reference cycles.
- R4: While enable is low, or out of reset, `scl_o` is 1 and `tick` and both strobes are 0. The first clock edge that samples enable high moves SCL low on the next cycle, and a full low phase follows.
- R5: Both strobes appear only in a cycle where `tick` is 1.
- R6: `sda_change_stb` pulses on the last tick of each low phase, and `scl_o` is 1 on the following cycle.
- R7: `sda_sample_stb` pulses on the tick with index floor(L/2) of a high phase of L ticks, counting the first tick as index 0.
- R8: The count registers keep the count in bits 4:0, and `lo_rd`/`hi_rd` read back with bits 7:5 equal to 1. After reset both counts are 1, so both read 0xE1.
- R9: Writing a count of 0 stores 1.
- R10: A mode write loads the prescaler select from bits 6:4 only if bit 3 of the same write is 1. Otherwise `presc_rd` is unchanged.
- R11: A new count or prescaler value takes effect at the next phase boundary. A write in the same cycle as a boundary takes effect at the boundary after that one.
- R12: Dropping enable in the middle of a phase returns SCL high on the next cycle. Raising it again restarts with a complete low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator while high |
| wr_mode | input | 1 | Mode write strobe (prescaler bits 6:4, key bit 3) |
| wr_low | input | 1 | Low-count write strobe (bits 4:0) |
| wr_high | input | 1 | High-count write strobe (bits 4:0) |
| wr_data | input | 8 | Write data shared by the three strobes |
| presc_rd | output | 3 | Stored prescaler select |
| lo_rd | output | 8 | Low-count readback, upper bits at 1 |
| hi_rd | output | 8 | High-count readback, upper bits at 1 |
| tick | output | 1 | Prescaled tick |
| scl_o | output | 1 | SCL drive level |
| sda_change_stb | output | 1 | End of low phase |
| sda_sample_stb | output | 1 | Middle of high phase |

## Verification
Two events can land in the same cycle: a configuration write and a phase boundary. The bench provokes this by watching for `sda_change_stb` and writing a new high count within that cycle. It then checks that the high phase just starting keeps the old length and that the next one uses the new value. A disable can also meet a pending tick. The bench drops enable in the middle of a phase and expects SCL high with no tick on the next cycle. A behavioural model compares every output on every clock.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } scl_phase_e;

    localparam int OVH_BYPASS  = 4;
    localparam int OVH_DIVIDED = 3;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mode,
    input  logic               wr_low,
    input  logic               wr_high,
    input  logic [REG_W-1:0]   wr_data,
    output logic [PRESC_W-1:0] presc_q,
    output logic [CNT_W-1:0]   lo_q,
    output logic [CNT_W-1:0]   hi_q,
    output logic [REG_W-1:0]   lo_rd,
    output logic [REG_W-1:0]   hi_rd
);
    localparam int KEY_BIT   = 3;
    localparam int PSEL_LSB  = 4;
    localparam int RSVD_W    = REG_W - CNT_W;

    logic [1:0]       we_vec;
    logic [CNT_W-1:0] cnt_q [2];
    logic [REG_W-1:0] rd_v  [2];
    logic             unused_msb;

    assign we_vec     = {wr_high, wr_low};
    assign unused_msb = wr_data[REG_W-1];

    // prescaler field accepted only with the key bit in the same write
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_q <= '0;
        else if (wr_mode && wr_data[KEY_BIT])
            presc_q <= wr_data[PSEL_LSB +: PRESC_W];
    end

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g] <= CNT_W'(1);
            else if (we_vec[g])
                cnt_q[g] <= (wr_data[CNT_W-1:0] == '0) ? CNT_W'(1)
                                                       : wr_data[CNT_W-1:0];
        end
        assign rd_v[g] = {{RSVD_W{1'b1}}, cnt_q[g]};
    end

    assign lo_q  = cnt_q[0];
    assign hi_q  = cnt_q[1];
    assign lo_rd = rd_v[0];
    assign hi_rd = rd_v[1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PRESC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] sel,
    output logic               tick
);
    localparam int DIV_W = (2 ** PRESC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++)
            mask[i] = (i < int'(sel));
    end

    assign tick = run && (div_q == mask);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic [PRESC_W-1:0] presc_reg,
    input  logic [CNT_W-1:0]   lo_reg,
    input  logic [CNT_W-1:0]   hi_reg,
    output logic [PRESC_W-1:0] sh_presc,
    output logic               run,
    output logic               scl_o,
    output logic               chg_stb,
    output logic               smp_stb
);
    localparam int LEN_W = CNT_W + 1;

    scl_phase_e       state_q, state_d;
    logic [LEN_W-1:0] ph_q, len_q;
    logic [PRESC_W-1:0] sh_presc_q;
    logic             last, load;

    function automatic logic [LEN_W-1:0] phase_len(input logic [CNT_W-1:0] cnt,
                                                   input logic [PRESC_W-1:0] psel);
        phase_len = LEN_W'(cnt) + ((psel == '0) ? LEN_W'(OVH_BYPASS) : LEN_W'(OVH_DIVIDED));
    endfunction

    assign last = (ph_q == len_q - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = S_LOW;
                S_LOW:  if (tick && last) state_d = S_HIGH;
                S_HIGH: if (tick && last) state_d = S_LOW;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // shadow copies refreshed only at phase start
    assign load = enable && ((state_q == S_IDLE) || (tick && last));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= '0;
            len_q      <= phase_len(CNT_W'(1), '0);
            sh_presc_q <= '0;
        end else begin
            if (!enable || state_q == S_IDLE)
                ph_q <= '0;
            else if (tick)
                ph_q <= last ? '0 : ph_q + LEN_W'(1);
            if (load) begin
                sh_presc_q <= presc_reg;
                len_q      <= phase_len((state_d == S_LOW) ? lo_reg : hi_reg, presc_reg);
            end
        end
    end

    always_comb begin
        sh_presc = sh_presc_q;
        run      = enable && (state_q != S_IDLE);
        scl_o    = (state_q != S_LOW);
        chg_stb  = tick && (state_q == S_LOW) && last;
        smp_stb  = tick && (state_q == S_HIGH) && (ph_q == (len_q >> 1));
    end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               wr_mode,
    input  logic               wr_low,
    input  logic               wr_high,
    input  logic [REG_W-1:0]   wr_data,
    output logic [PRESC_W-1:0] presc_rd,
    output logic [REG_W-1:0]   lo_rd,
    output logic [REG_W-1:0]   hi_rd,
    output logic               tick,
    output logic               scl_o,
    output logic               sda_change_stb,
    output logic               sda_sample_stb
);
    logic [CNT_W-1:0]   lo_q, hi_q;
    logic [PRESC_W-1:0] sh_presc;
    logic               run;

    scl_cfg_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_mode),
        .wr_low  (wr_low),
        .wr_high (wr_high),
        .wr_data (wr_data),
        .presc_q (presc_rd),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .lo_rd   (lo_rd),
        .hi_rd   (hi_rd)
    );

    scl_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sh_presc),
        .tick  (tick)
    );

    scl_phase_fsm #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .presc_reg (presc_rd),
        .lo_reg    (lo_q),
        .hi_reg    (hi_q),
        .sh_presc  (sh_presc),
        .run       (run),
        .scl_o     (scl_o),
        .chg_stb   (sda_change_stb),
        .smp_stb   (sda_sample_stb)
    );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
    parameter int PRESC_W = 3,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               wr_mode,
    input logic               key_bit,
    input logic [PRESC_W-1:0] presc_rd,
    input logic [CNT_W-1:0]   lo_cnt,
    input logic               tick,
    input logic               scl_o,
    input logic               sda_change_stb,
    input logic               sda_sample_stb
);
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !tick));

    a_r5_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_change_stb || sda_sample_stb) |-> tick);

    a_r6_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change_stb |-> !scl_o);

    a_r6_high_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change_stb |=> scl_o);

    a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |-> ($past(sda_change_stb) || !$past(enable)));

    a_r7_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample_stb |-> scl_o);

    a_r9_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt != '0);

    a_r10_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !key_bit) |=> $stable(presc_rd));
endmodule

bind scl_rate_gen scl_rate_gen_chk #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .wr_mode        (wr_mode),
    .key_bit        (wr_data[3]),
    .presc_rd       (presc_rd),
    .lo_cnt         (lo_rd[CNT_W-1:0]),
    .tick           (tick),
    .scl_o          (scl_o),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb)
);

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       enable = 0;
    logic       wr_mode = 0, wr_low = 0, wr_high = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] presc_rd;
    logic [7:0] lo_rd, hi_rd;
    logic       tick, scl_o, sda_change_stb, sda_sample_stb;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    scl_rate_gen u_scl_rate_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr_mode(wr_mode), .wr_low(wr_low), .wr_high(wr_high), .wr_data(wr_data),
        .presc_rd(presc_rd), .lo_rd(lo_rd), .hi_rd(hi_rd),
        .tick(tick), .scl_o(scl_o),
        .sda_change_stb(sda_change_stb), .sda_sample_stb(sda_sample_stb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_presc, m_lo, m_hi, m_state, m_div, m_ph, m_len, m_sh;

    function automatic int ovh(input int s);
        return (s == 0) ? 4 : 3;
    endfunction

    function automatic bit e_tick();
        return enable && m_state != 0 && m_div == (1 << m_sh) - 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_presc = 0; m_lo = 1; m_hi = 1;
            m_state = 0; m_div = 0; m_ph = 0; m_sh = 0; m_len = 5;
        end else begin
            if (!enable) begin
                m_state = 0; m_div = 0; m_ph = 0;
            end else if (m_state == 0) begin
                m_state = 1; m_div = 0; m_ph = 0;
                m_sh = m_presc; m_len = m_lo + ovh(m_presc);
            end else if (e_tick()) begin
                m_div = 0;
                if (m_ph == m_len - 1) begin
                    m_state = (m_state == 1) ? 2 : 1;
                    m_ph = 0; m_sh = m_presc;
                    m_len = ((m_state == 1) ? m_lo : m_hi) + ovh(m_presc);
                end else begin
                    m_ph++;
                end
            end else begin
                m_div++;
            end
            if (wr_mode && wr_data[3]) m_presc = int'(wr_data[6:4]);
            if (wr_low)  m_lo = (wr_data[4:0] == 0) ? 1 : int'(wr_data[4:0]);
            if (wr_high) m_hi = (wr_data[4:0] == 0) ? 1 : int'(wr_data[4:0]);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit t;
            t = e_tick();
            check("R1 tick", tick, t);
            check("R2/R3/R4/R12 scl", scl_o, (m_state != 1));
            check("R5/R6 change strobe", sda_change_stb, t && m_state == 1 && m_ph == m_len - 1);
            check("R5/R7 sample strobe", sda_sample_stb, t && m_state == 2 && m_ph == m_len / 2);
            check("R8/R9 lo readback", lo_rd, 32'hE0 | m_lo);
            check("R8/R9 hi readback", hi_rd, 32'hE0 | m_hi);
            check("R10 presc readback", presc_rd, m_presc);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int which, input logic [7:0] d);
        @(negedge clk); #2;
        wr_data = d;
        wr_mode = (which == 0); wr_low = (which == 1); wr_high = (which == 2);
        @(negedge clk); #2;
        wr_mode = 0; wr_low = 0; wr_high = 0;
    endtask

    task automatic measure(output int lo_n, output int hi_n);
        do @(negedge clk); while (scl_o !== 1'b1);
        do @(negedge clk); while (scl_o !== 1'b0);
        lo_n = 0;
        while (scl_o === 1'b0) begin lo_n++; @(negedge clk); end
        hi_n = 0;
        while (scl_o === 1'b1) begin hi_n++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int a, b, n;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check("R4 reset scl", scl_o, 1);
        check("R4 reset tick", tick, 0);
        check("R8 reset lo", lo_rd, 8'hE1);
        check("R8 reset hi", hi_rd, 8'hE1);

        // R2: bypassed prescaler
        wr(1, 8'h05); wr(2, 8'h03); wr(0, 8'h08);
        check("R8 lo write", lo_rd, 8'hE5);
        @(negedge clk); #2 enable = 1;
        @(negedge clk);
        check("R4 low after enable", scl_o, 0);
        measure(a, b);
        check("R2 low length", a, 9);
        check("R2 high length", b, 7);

        // R10 key guard then R3 divided timing
        wr(0, 8'h20);
        check("R10 no key ignored", presc_rd, 0);
        wr(0, 8'h28);
        check("R10 keyed write", presc_rd, 2);
        wr(1, 8'h02); wr(2, 8'h06);
        measure(a, b);
        measure(a, b);
        check("R3 low length", a, 20);
        check("R3 high length", b, 36);

        // R9 zero count
        wr(1, 8'h00);
        check("R9 zero stored as one", lo_rd, 8'hE1);

        // R11 write on the boundary cycle
        wr(0, 8'h08); wr(1, 8'h04); wr(2, 8'h04);
        measure(a, b);
        do @(negedge clk); while (sda_change_stb !== 1'b1);
        #2 wr_high = 1; wr_data = 8'h0A;
        @(negedge clk); #2 wr_high = 0;
        n = 0;
        #0;
        while (scl_o === 1'b1) begin n++; @(negedge clk); end
        check("R11 boundary write keeps old", n, 8);
        measure(a, b);
        check("R11 new value next phase", b, 14);

        // R12 abort mid low phase and restart
        do @(negedge clk); while (scl_o !== 1'b0);
        @(negedge clk); #2 enable = 0;
        @(negedge clk);
        check("R12 abort scl high", scl_o, 1);
        check("R12 abort no tick", tick, 0);
        #2 enable = 1;
        @(negedge clk);
        n = 0;
        while (scl_o === 1'b0) begin n++; @(negedge clk); end
        check("R12 full low after restart", n, 8);

        // R1 deepest prescaler
        wr(1, 8'h01); wr(2, 8'h01); wr(0, 8'h78);
        repeat (2200) @(negedge clk);
        measure(a, b);
        check("R1 presc 7 low", a, 512);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule